// File: doc/BRIEF.md
# Cache Line Zeroing Unit

This unit carries out a zero-cache-block request. A request arrives with a byte address and a flag that marks the long form. The unit works out the effective line size and clears the address low bits to reach the line base. It then issues one 32-bit zero write per word across the whole line, in rising address order, through a simple write port that the memory side acknowledges.

When the last write has been acknowledged, the unit signals completion. In that same cycle it clears a load reservation that points exactly at the line base. The reservation register lives in the unit, and the surrounding core loads it through a set strobe.

A two-bit configuration input selects the normal line size. For the short form only, a model-enable bit together with a two-bit subfield of a mode-control word can force a 32-byte line. The long form never sees that override.

The controller is a three-state machine:
- **IDLE** waits for a request. On `req_valid` it takes the transition *accept* to WRITE, and latches the aligned base and the word count.
- **WRITE** holds `mem_wr_valid` high. Each acknowledged write that is not the last takes the *step* self-loop. The acknowledged last write takes *last_ack* to FINISH, and that same edge updates the reservation.
- **FINISH** raises `done` for one cycle and takes *retire* back to IDLE.

Top module: `line_zero_unit`

## Requirements
- R1: The first write address is the request address with its low log2(L) bits cleared, where L is the effective line size in bytes.
- R2: The unit writes data 0 to base, base+4, base+8 and so on up to base+L-4. That is exactly L/4 writes, one per acknowledged cycle. While `mem_wr_ack` is low, the address is held.
- R3: `cfg_line_sel` encodes the normal line size: 00 = 32 bytes, 01 = 64 bytes, 10 and 11 = 128 bytes.
- R4: For a short-form request (`req_long`=0) with `force_en`=1 and `mode_ctl[8:7]`=01, the line is 32 bytes whatever `cfg_line_sel` holds. Any other value of those two bits, or `force_en`=0, leaves the size from R3.
- R5: A long-form request (`req_long`=1) always uses the size from R3, whatever `force_en` and `mode_ctl` hold.
- R6: `done` is high for exactly one cycle: the cycle after the clock edge that takes the last acknowledged write. `mem_wr_valid` is low in that cycle.
- R7: If `resv_addr` equals the aligned base when the last write is acknowledged, `resv_addr` reads all ones (invalid) in the `done` cycle. Any other value, including another address inside the same line, is left unchanged.
- R8: `resv_set` loads `resv_set_addr` into `resv_addr` at the next edge. It takes priority over the invalidation of R7 when both fall on the same edge.
- R9: A `req_valid` seen in WRITE or in FINISH is ignored. It neither restarts the current line nor starts a new one.
- R10: After reset, `mem_wr_valid` and `done` are low and `resv_addr` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Zeroing request, taken in IDLE only |
| req_addr | input | AW | Byte address inside the target line |
| req_long | input | 1 | 1 = long form, which is immune to the 32-byte override |
| cfg_line_sel | input | 2 | Normal line size code (R3) |
| force_en | input | 1 | Model enable for the 32-byte override |
| mode_ctl | input | MODE_W | Mode-control word; bits 8:7 drive the override |
| mem_wr_valid | output | 1 | Word write request |
| mem_wr_addr | output | AW | Word write byte address |
| mem_wr_data | output | 32 | Word write data (zero) |
| mem_wr_ack | input | 1 | Memory accepts the current write |
| resv_set | input | 1 | Load the reservation register |
| resv_set_addr | input | AW | Value to load into the reservation register |
| resv_addr | output | AW | Reservation address; all ones means invalid |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first write is visible in the cycle after the accepting edge, because one register stage sits between request and port. Each following address appears one cycle after the acknowledging edge. `done` and the updated `resv_addr` are both due in the cycle that follows the edge taking the final acknowledgement. The bench drives inputs on the falling edge and samples the outputs on that same falling edge. It counts acknowledgements itself and expects `done` and the reservation result at the first falling edge after the count reaches L/4. It expects `done` low again one falling edge later. It sweeps every combination of size code, form, model enable and override bits, under an irregular acknowledgement pattern.

// File: rtl/lz_pkg.sv
package lz_pkg;
    typedef enum logic [1:0] {
        LZ_IDLE   = 2'd0,
        LZ_WRITE  = 2'd1,
        LZ_FINISH = 2'd2
    } lz_state_e;

    // Smallest line the unit handles: 32 bytes.
    localparam int unsigned LZ_MIN_LOG2 = 5;
    // Override code expected in the two-bit mode subfield.
    localparam logic [1:0] LZ_FORCE_CODE = 2'b01;
endpackage

// File: rtl/lz_size_sel.sv
module lz_size_sel
    import lz_pkg::*;
#(
    parameter int unsigned MAX_LOG2 = 7,
    parameter int unsigned MODE_W   = 16,
    parameter int unsigned MODE_LO  = 7,
    localparam int unsigned LOG2_W  = $clog2(MAX_LOG2 + 1),
    localparam int unsigned IDX_W   = MAX_LOG2 - 2
) (
    input  logic [1:0]        cfg_line_sel,
    input  logic              req_long,
    input  logic              force_en,
    input  logic [MODE_W-1:0] mode_ctl,
    output logic [LOG2_W-1:0] eff_log2,
    output logic [IDX_W-1:0]  words_m1
);
    logic              force_32;
    logic [LOG2_W-1:0] cfg_log2;

    // Only the short form may be pulled down to 32 bytes.
    assign force_32 = !req_long && force_en
                      && (mode_ctl[MODE_LO+1:MODE_LO] == LZ_FORCE_CODE);

    always_comb begin
        unique case (cfg_line_sel)
            2'b00:   cfg_log2 = LOG2_W'(LZ_MIN_LOG2);
            2'b01:   cfg_log2 = LOG2_W'(LZ_MIN_LOG2 + 1);
            default: cfg_log2 = LOG2_W'(LZ_MIN_LOG2 + 2);
        endcase
    end

    assign eff_log2 = force_32 ? LOG2_W'(LZ_MIN_LOG2) : cfg_log2;
    assign words_m1 = IDX_W'((1 << (eff_log2 - 2)) - 1);

    logic unused_mode_bits;
    assign unused_mode_bits = ^mode_ctl;
endmodule

// File: rtl/lz_resv.sv
module lz_resv #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          kill_chk,
    input  logic [AW-1:0] line_base,
    output logic [AW-1:0] resv_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resv_q <= '1;
        end else if (set) begin
            resv_q <= set_addr;
        end else if (kill_chk && (resv_q == line_base)) begin
            resv_q <= '1;
        end
    end

    AST_RESV_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_chk && !set && resv_q == line_base) |=> (resv_q == '1)); // R7
    AST_RESV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_chk && !set && resv_q != line_base) |=> $stable(resv_q)); // R7
    AST_RESV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (resv_q == $past(set_addr))); // R8
endmodule

// File: rtl/line_zero_unit.sv
module line_zero_unit
    import lz_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned MAX_LOG2 = 7,
    parameter int unsigned MODE_W   = 16,
    parameter int unsigned MODE_LO  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_long,
    input  logic [1:0]        cfg_line_sel,
    input  logic              force_en,
    input  logic [MODE_W-1:0] mode_ctl,
    output logic              mem_wr_valid,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ack,
    input  logic              resv_set,
    input  logic [AW-1:0]     resv_set_addr,
    output logic [AW-1:0]     resv_addr,
    output logic              done
);
    localparam int unsigned LOG2_W = $clog2(MAX_LOG2 + 1);
    localparam int unsigned IDX_W  = MAX_LOG2 - 2;

    lz_state_e         state_q, state_d;
    logic [LOG2_W-1:0] eff_log2;
    logic [IDX_W-1:0]  words_m1;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [AW-1:0]     base_q, low_mask;
    logic              accept, step, last_ack;

    lz_size_sel #(
        .MAX_LOG2 (MAX_LOG2),
        .MODE_W   (MODE_W),
        .MODE_LO  (MODE_LO)
    ) u_size (
        .cfg_line_sel (cfg_line_sel),
        .req_long     (req_long),
        .force_en     (force_en),
        .mode_ctl     (mode_ctl),
        .eff_log2     (eff_log2),
        .words_m1     (words_m1)
    );

    assign low_mask = (AW'(1) << eff_log2) - AW'(1);
    assign accept   = (state_q == LZ_IDLE) && req_valid;
    assign step     = (state_q == LZ_WRITE) && mem_wr_ack;
    assign last_ack = step && (idx_q == last_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LZ_IDLE:   if (req_valid) state_d = LZ_WRITE;
            LZ_WRITE:  if (last_ack)  state_d = LZ_FINISH;
            LZ_FINISH: state_d = LZ_IDLE;
            default:   state_d = LZ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LZ_IDLE;
        else        state_q <= state_d;
    end

    // Line base and word walk.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (accept) begin
            base_q <= req_addr & ~low_mask;
            idx_q  <= '0;
            last_q <= words_m1;
        end else if (step && !last_ack) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        mem_wr_valid = (state_q == LZ_WRITE);
        done         = (state_q == LZ_FINISH);
        mem_wr_addr  = base_q + (AW'(idx_q) << 2);
        mem_wr_data  = '0;
    end

    lz_resv #(.AW(AW)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (resv_set),
        .set_addr  (resv_set_addr),
        .kill_chk  (last_ack),
        .line_base (base_q),
        .resv_q    (resv_addr)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ack) |=> (mem_wr_valid && $stable(mem_wr_addr))); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_ack) |=> (done || mem_wr_addr == $past(mem_wr_addr) + AW'(4))); // R2
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_wr_valid && mem_wr_ack)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mem_wr_valid)); // R6
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && mem_wr_valid)); // R6
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ack && req_valid) |=> $stable(mem_wr_addr)); // R9
endmodule

// File: tb/line_zero_unit_bench.sv
module line_zero_unit_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_long = 1'b0;
    logic [1:0]    cfg_line_sel = 2'b00;
    logic          force_en = 1'b0;
    logic [15:0]   mode_ctl = '0;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0]   mem_wr_data;
    logic          mem_wr_ack = 1'b0;
    logic          resv_set = 1'b0;
    logic [AW-1:0] resv_set_addr = '0;
    logic [AW-1:0] resv_addr;
    logic          done;

    int total = 0;
    int bad   = 0;
    int pat   = 0;

    always #4 clk = ~clk;

    line_zero_unit u_line_zero_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_long(req_long), .cfg_line_sel(cfg_line_sel), .force_en(force_en),
        .mode_ctl(mode_ctl), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .resv_set(resv_set),
        .resv_set_addr(resv_set_addr), .resv_addr(resv_addr), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_log2(input int sel, input bit lng, input bit fen,
                                    input int mb);
        if (!lng && fen && mb == 1) return 5;   // R4 override, R5 excludes long
        if (sel == 0) return 5;                 // R3
        if (sel == 1) return 6;
        return 7;
    endfunction

    // resv_mode: 0 = same as base, 1 = base+4, 2 = neighbour line
    // prio: load a new reservation on the edge of the last acknowledgement
    task automatic run_op(input logic [AW-1:0] addr, input int sel, input bit lng,
                          input bit fen, input int mb, input int resv_mode,
                          input bit prio);
        int lg = exp_log2(sel, lng, fen, mb);
        int words = (1 << lg) / 4;
        logic [AW-1:0] base = addr & ~((AW'(1) << lg) - 1);
        logic [AW-1:0] rv;
        logic [AW-1:0] exp_rv;
        int k = 0;
        int guard = 0;
        rv = (resv_mode == 0) ? base : (resv_mode == 1) ? base + 4 : base ^ (AW'(1) << lg);
        @(negedge clk);
        resv_set = 1'b1; resv_set_addr = rv;
        @(negedge clk);
        resv_set = 1'b0;
        check(resv_addr == rv, "R8 load", resv_addr, rv);
        req_valid = 1'b1; req_addr = addr; req_long = lng;
        cfg_line_sel = sel[1:0]; force_en = fen; mode_ctl = 16'(mb << 7) | 16'h0123 & ~16'h0180;
        @(negedge clk);
        req_valid = 1'b0;
        while (k < words && guard < 2000) begin
            guard++;
            check(mem_wr_valid == 1'b1 && done == 1'b0, "R2 valid", mem_wr_valid, 1);
            check(mem_wr_addr == base + AW'(4 * k), "R1/R2 addr", mem_wr_addr,
                  base + AW'(4 * k));
            check(mem_wr_data == 32'h0, "R2 data", mem_wr_data, 0);
            // R9: a request mid-line must be ignored
            req_valid = (guard == 2);
            req_addr  = addr ^ 32'h0000_4000;
            mem_wr_ack = (pat % 3) != 2;
            pat++;
            resv_set = 1'b0;
            if (mem_wr_ack) begin
                k++;
                if (prio && k == words) begin
                    resv_set = 1'b1; resv_set_addr = 32'hCAFE_0000;
                end
            end
            @(negedge clk);
        end
        req_valid = 1'b0; mem_wr_ack = 1'b0; resv_set = 1'b0;
        check(done == 1'b1, "R6 done due", done, 1);
        check(mem_wr_valid == 1'b0, "R6 valid low", mem_wr_valid, 0);
        exp_rv = prio ? 32'hCAFE_0000 : (resv_mode == 0) ? '1 : rv;
        check(resv_addr == exp_rv, prio ? "R8 priority" : "R7 reservation",
              resv_addr, exp_rv);
        req_valid = 1'b1; req_addr = addr;   // R9: request during FINISH
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b0, "R6 pulse", done, 0);
        check(mem_wr_valid == 1'b0, "R9 finish req ignored", mem_wr_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_wr_valid == 1'b0, "R10 valid", mem_wr_valid, 0);
        check(done == 1'b0, "R10 done", done, 0);
        check(resv_addr == '1, "R10 resv", resv_addr, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        for (int sel = 0; sel < 4; sel++)
            for (int lng = 0; lng < 2; lng++)
                for (int fen = 0; fen < 2; fen++)
                    for (int mb = 0; mb < 4; mb++) begin
                        int op = ((sel * 2 + lng) * 2 + fen) * 4 + mb;
                        run_op(32'h1000_0000 + AW'(op * 32'h1357), sel, lng[0], fen[0],
                               mb, op % 3, 1'b0);
                    end
        run_op(32'h2000_00FC, 2, 1'b0, 1'b0, 0, 0, 1'b1);
        run_op(32'h3000_007F, 0, 1'b1, 1'b1, 1, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule